// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is a chain of flip-flops that turns a serial bit stream into a parallel word. Two serial data pins feed the chain through an AND gate. One pin can therefore act as an enable for the other: holding one high passes the other through, and a low on either pushes a zero into the chain.

On every rising clock edge the gated bit enters the first stage, and each later stage copies its neighbour. All stages are visible at once on one packed output vector. Bit 0 of that vector is the entry stage.

An active-low clear empties the whole chain at once, without a clock edge. While clear is held low it overrides the clock and both data pins.

Top module: `gated_sipo`

## Requirements
- R1: The output `stage_q` is a packed vector of `STAGES` bits (default 8). Bit 0 is the entry stage and bit `STAGES-1` is the last stage. After clear, every bit reads 0.
- R2: The chain changes only on a low-to-high clock transition. A high-to-low transition leaves `stage_q` unchanged.
- R3: On a rising edge with clear inactive, `stage_q[0]` loads `ser_a AND ser_b` as sampled at that edge.
- R4: If `ser_a` is low, `ser_b` is low, or both are low at a rising edge, `stage_q[0]` becomes 0.
- R5: While one serial pin is held high, the other pin alone sets the bit that enters `stage_q[0]`.
- R6: On each rising edge, `stage_q[i]` for i from 1 to `STAGES-1` takes the value `stage_q[i-1]` held just before that edge.
- R7: Driving `clr_n` low forces every bit of `stage_q` to 0 immediately, without any clock edge.
- R8: While `clr_n` is low, rising clock edges and serial input values leave `stage_q` at all zeros.
- R9: After `clr_n` returns high, the first rising edge shifts normally.
- R10: A single 1 that enters `stage_q[0]` reaches `stage_q[STAGES-1]` after exactly `STAGES` rising edges, counting its entry edge, when no clear occurs in between.
- R11: Changes on the serial pins between rising edges have no effect on `stage_q`. Only the values present at the edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain advances on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | Serial data pin A, ANDed with B |
| ser_b | input | 1 | Serial data pin B, ANDed with A |
| stage_q | output | STAGES | Parallel view of all stages; bit 0 is the entry stage |

## Verification
The hardest case to reach from the ports is a clear that arrives with no clock edge around it. The bench pulls `clr_n` low in the middle of the clock's high phase, while a patterned word is in the chain, and checks for all zeros before the next edge. It then holds clear low across several edges with both serial pins high, to show that clear wins over the clock and inputs. It releases clear between edges and checks that the very next edge loads the first stage.

// File: rtl/gated_sipo.sv
module gated_sipo #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ser_a,
  input  logic              ser_b,
  output logic [STAGES-1:0] stage_q
);

  logic gated_bit;
  assign gated_bit = ser_a & ser_b;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], gated_bit};
  end

  assert_entry_and_R3: assert property (@(posedge clk) disable iff (!clr_n)
    $past(clr_n) |-> stage_q[0] == $past(ser_a && ser_b));

  assert_low_blocks_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (!ser_a || !ser_b) |=> !stage_q[0]);

  assert_chain_step_R6: assert property (@(posedge clk) disable iff (!clr_n)
    $past(clr_n) |-> stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]));

  assert_clear_holds_R8: assert property (@(posedge clk)
    !clr_n |-> stage_q == '0);

endmodule

// File: tb/test_gated_sipo.sv
module test_gated_sipo;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic ser_a = 1'b0;
  logic ser_b = 1'b0;
  logic [W-1:0] stage_q;
  logic [W-1:0] model_q;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  gated_sipo #(.STAGES(W)) i_gated_sipo (
    .clk(clk), .clr_n(clr_n), .ser_a(ser_a), .ser_b(ser_b), .stage_q(stage_q)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] exp);
    tests++;
    if (stage_q !== exp) begin
      fails++;
      $display("FAIL %s: stage_q=%b expected=%b", req, stage_q, exp);
    end
  endtask

  task automatic shift(input logic a, input logic b, input string req);
    ser_a = a;
    ser_b = b;
    @(posedge clk);
    #2;
    model_q = {model_q[W-2:0], a & b};
    check(req, model_q);
  endtask

  task automatic t_reset;
    #2;
    check("R1 reset", '0);
    @(negedge clk);
    #1;
    clr_n = 1'b1;
    model_q = '0;
  endtask

  task automatic t_gating;
    shift(1'b1, 1'b1, "R3 a=1 b=1");
    shift(1'b0, 1'b1, "R4 a=0 b=1");
    shift(1'b1, 1'b0, "R4 a=1 b=0");
    shift(1'b0, 1'b0, "R4 a=0 b=0");
    shift(1'b1, 1'b1, "R3 a=1 b=1 again");
    shift(1'b1, 1'b0, "R5 a held high, b=0");
    shift(1'b1, 1'b1, "R5 a held high, b=1");
    shift(1'b0, 1'b1, "R5 b held high, a=0");
    shift(1'b1, 1'b1, "R5 b held high, a=1");
  endtask

  task automatic t_falling;
    @(negedge clk);
    #1;
    check("R2 falling edge no change", model_q);
  endtask

  task automatic t_walk;
    for (int i = 0; i < W; i++) shift(1'b0, 1'b0, "R6 flush");
    shift(1'b1, 1'b1, "R10 inject single one");
    for (int i = 1; i < W; i++) begin
      shift(1'b0, 1'b1, "R6 walk step");
    end
    tests++;
    if (stage_q[W-1] !== 1'b1) begin
      fails++;
      $display("FAIL R10: stage_q[%0d]=%b expected=1", W - 1, stage_q[W-1]);
    end
    shift(1'b0, 1'b0, "R6 one leaves chain");
  endtask

  task automatic t_between;
    shift(1'b1, 1'b1, "R11 setup");
    shift(1'b0, 1'b1, "R11 setup");
    shift(1'b1, 1'b1, "R11 setup");
    ser_a = 1'b1; ser_b = 1'b1; #1;
    ser_a = 1'b0; #1;
    ser_b = 1'b0; #1;
    check("R11 wiggle without edge", model_q);
    shift(1'b0, 1'b1, "R11 only edge value counts");
  endtask

  task automatic t_clear;
    shift(1'b1, 1'b1, "R7 setup");
    shift(1'b0, 1'b1, "R7 setup");
    @(posedge clk);
    #1;
    model_q = {model_q[W-2:0], 1'b0};
    clr_n = 1'b0;
    #1;
    check("R7 async clear mid-phase", '0);
    ser_a = 1'b1;
    ser_b = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #2;
      check("R8 clear overrides edge and inputs", '0);
    end
    @(negedge clk);
    #1;
    clr_n = 1'b1;
    model_q = '0;
    shift(1'b1, 1'b1, "R9 first edge after release");
    shift(1'b1, 1'b0, "R9 second edge after release");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_gating();
    t_falling();
    t_walk();
    t_falling();
    t_between();
    t_clear();
    t_falling();
    finish_run();
  end

  initial begin
    #100000;
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule